// File: doc/BRIEF.md
# Priority Pin Crossbar Decoder

This block decides which on-chip peripheral signal drives each of seventeen general-purpose port pins. Seventeen peripheral signals are ranked in a fixed order. Each enabled signal, taken from highest to lowest rank, takes the lowest pin that is still free. Two peripherals do not take part in that search. The serial port transmit/receive pair and the two comparator outputs always sit on fixed pins whenever they are enabled.

Software excludes pins from the search through two 8-bit skip masks, one for port 0 and one for port 1. A skipped pin counts as occupied. This is how pins that are used for analog inputs, the oscillator, the conversion-start input or the current-DAC outputs are kept away from the crossbar. The block never assigns those pins on its own.

The decode is combinational from the configuration inputs. It is captured in output registers on every clock, so a configuration change shows up at the outputs one cycle later. A pin that no signal claims reports index 31 and falls back to GPIO. An enabled signal that finds no free pin is flagged as not routed.

Top module: `pin_route_xbar`

## Requirements
- R1: While `rst_n` is low, every pin reports index 31 with its claim flag clear, and every `unrouted` bit is 0.
- R2: Signal indices run from highest to lowest priority:
  - 0 TX, 1 RX, 2 CP0A, 3 CP0;
  - 4 SCK, 5 MISO, 6 MOSI, 7 NSS;
  - 8 SDA, 9 SCL, 10 SYSCLK;
  - 11 to 13 CEX0 to CEX2, 14 ECI, 15 T0, 16 T1.
  - No index appears on more than one pin.
- R3: Searched signals go, in priority order, to the lowest free pin. Pin numbers 0 to 7 are port 0 bits 0 to 7, numbers 8 to 15 are port 1 bits 0 to 7, and number 16 is port 2 bit 0. Each pin's index sits in `pin_sel[5*p +: 5]`.
- R4: With `uart_en` set, TX takes pin 4 and RX takes pin 5, whatever the skip masks hold. Neither takes part in the search.
- R5: `cp0a_en` puts CP0A on pin 12 (port 1 bit 4) and `cp0_en` puts CP0 on pin 13 (port 1 bit 5), whatever the skip masks hold.
- R6: A pin whose skip bit is set is passed over by the search. It stays unclaimed unless a fixed assignment (R4, R5) owns it.
- R7: NSS is routed only when both `spi_en` and `spi_4wire` are set. SCK, MISO and MOSI follow `spi_en` alone.
- R8: An enabled searched signal that finds no free pin has its `unrouted` bit set, at the bit position equal to its index. Every lower-priority enabled signal is then also unrouted.
- R9: The outputs show the decode of the configuration sampled at the previous rising clock edge, and do not change between edges.
- R10: An unclaimed pin reports index 31 with `pin_claimed` clear. A claimed pin reports its signal index with `pin_claimed` set.
- R11: `pca_chans` (0 to 3) enables CEX0 up to CEX(n-1). `smb_en` enables SDA and SCL together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uart_en | input | 1 | Serial port enable (TX, RX fixed) |
| cp0a_en | input | 1 | Asynchronous comparator output enable |
| cp0_en | input | 1 | Synchronous comparator output enable |
| spi_en | input | 1 | SPI enable |
| spi_4wire | input | 1 | SPI 4-wire mode (adds NSS) |
| smb_en | input | 1 | Two-wire bus enable |
| sysclk_en | input | 1 | System clock output enable |
| pca_chans | input | 2 | Number of capture/compare outputs enabled |
| eci_en | input | 1 | Counter clock input enable |
| t0_en | input | 1 | Timer 0 input enable |
| t1_en | input | 1 | Timer 1 input enable |
| p0_skip | input | 8 | Port 0 skip mask |
| p1_skip | input | 8 | Port 1 skip mask |
| pin_sel | output | 85 | Per-pin 5-bit signal index, 31 = GPIO |
| pin_claimed | output | 17 | Per-pin claimed flag |
| unrouted | output | 17 | Per-signal no-free-pin flag |

## Verification
The bench drives configurations in which the fixed pins fall in the middle of the search range. A design that let the search claim pins 4, 5, 12 or 13 would shift every later signal by one pin.

It fills the pin space exactly, so that T1 lands on the port 2 pin. It then removes one pin, so that T1 must be flagged unrouted. An off-by-one search bound would either drop T1 too early or route it to a pin that does not exist.

Other cases cover:
- skip bits set on the fixed pins, which must not block the serial port;
- 3-wire SPI, which must leave NSS off;
- several hundred random configurations, compared against a pointer-based model;
- a hold check between edges, which catches an output that follows the inputs combinationally.

// File: rtl/pin_route_xbar.sv
module pin_route_xbar #(
  parameter int NPINS = 17,
  parameter int NSIG  = 17,
  parameter int IW    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uart_en,
  input  logic              cp0a_en,
  input  logic              cp0_en,
  input  logic              spi_en,
  input  logic              spi_4wire,
  input  logic              smb_en,
  input  logic              sysclk_en,
  input  logic [1:0]        pca_chans,
  input  logic              eci_en,
  input  logic              t0_en,
  input  logic              t1_en,
  input  logic [7:0]        p0_skip,
  input  logic [7:0]        p1_skip,
  output logic [NPINS*IW-1:0] pin_sel,
  output logic [NPINS-1:0]  pin_claimed,
  output logic [NSIG-1:0]   unrouted
);
  localparam logic [IW-1:0] GPIO = '1;
  localparam int FIRST_SEARCHED = 4;
  localparam int TX_PIN = 4, RX_PIN = 5, CPA_PIN = 12, CP_PIN = 13;

  logic [NSIG-1:0]  want;
  logic [NPINS-1:0] taken, claim_d, claim_q;
  logic [NSIG-1:0]  miss_d, miss_q;
  logic [IW-1:0]    sel_d [NPINS];
  logic [IW-1:0]    sel_q [NPINS];
  logic             found;

  always_comb begin
    want      = '0;
    want[0]   = uart_en;
    want[1]   = uart_en;
    want[2]   = cp0a_en;
    want[3]   = cp0_en;
    want[4]   = spi_en;
    want[5]   = spi_en;
    want[6]   = spi_en;
    want[7]   = spi_en & spi_4wire;
    want[8]   = smb_en;
    want[9]   = smb_en;
    want[10]  = sysclk_en;
    want[11]  = pca_chans != 2'd0;
    want[12]  = pca_chans[1];
    want[13]  = pca_chans == 2'd3;
    want[14]  = eci_en;
    want[15]  = t0_en;
    want[16]  = t1_en;
  end

  always_comb begin
    taken   = {{(NPINS-16){1'b0}}, p1_skip, p0_skip};
    claim_d = '0;
    miss_d  = '0;
    found   = 1'b0;
    for (int p = 0; p < NPINS; p++) sel_d[p] = GPIO;

    if (want[0]) begin
      sel_d[TX_PIN] = IW'(0); taken[TX_PIN] = 1'b1; claim_d[TX_PIN] = 1'b1;
      sel_d[RX_PIN] = IW'(1); taken[RX_PIN] = 1'b1; claim_d[RX_PIN] = 1'b1;
    end
    if (want[2]) begin
      sel_d[CPA_PIN] = IW'(2); taken[CPA_PIN] = 1'b1; claim_d[CPA_PIN] = 1'b1;
    end
    if (want[3]) begin
      sel_d[CP_PIN] = IW'(3); taken[CP_PIN] = 1'b1; claim_d[CP_PIN] = 1'b1;
    end

    for (int s = FIRST_SEARCHED; s < NSIG; s++) begin
      if (want[s]) begin
        found = 1'b0;
        for (int p = 0; p < NPINS; p++) begin
          if (!found && !taken[p]) begin
            found      = 1'b1;
            taken[p]   = 1'b1;
            claim_d[p] = 1'b1;
            sel_d[p]   = IW'(s);
          end
        end
        if (!found) miss_d[s] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      claim_q <= '0;
      miss_q  <= '0;
      for (int p = 0; p < NPINS; p++) sel_q[p] <= GPIO;
    end else begin
      claim_q <= claim_d;
      miss_q  <= miss_d;
      for (int p = 0; p < NPINS; p++) sel_q[p] <= sel_d[p];
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_out
    assign pin_sel[p*IW +: IW] = sel_q[p];
  end
  assign pin_claimed = claim_q;
  assign unrouted    = miss_q;
endmodule

module pin_route_xbar_chk #(
  parameter int NPINS = 17,
  parameter int NSIG  = 17,
  parameter int IW    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              uart_en,
  input logic              cp0a_en,
  input logic              cp0_en,
  input logic              spi_en,
  input logic              spi_4wire,
  input logic [7:0]        p0_skip,
  input logic [7:0]        p1_skip,
  input logic [NPINS*IW-1:0] pin_sel,
  input logic [NPINS-1:0]  pin_claimed,
  input logic [NSIG-1:0]   unrouted
);
  logic [NPINS-1:0] hit [NSIG];
  logic [NSIG-1:0]  dup;

  for (genvar s = 0; s < NSIG; s++) begin : g_sig
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
      assign hit[s][p] = pin_sel[p*IW +: IW] == IW'(s);
    end
    assign dup[s] = $countones(hit[s]) > 1;
  end

  // R4
  uart_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uart_en |=> pin_sel[4*IW +: IW] == 0 && pin_sel[5*IW +: IW] == 1 && pin_claimed[4] && pin_claimed[5]);

  // R5
  cmpa_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cp0a_en |=> pin_sel[12*IW +: IW] == 2 && pin_claimed[12]);

  // R5
  cmp_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cp0_en |=> pin_sel[13*IW +: IW] == 3 && pin_claimed[13]);

  // R7
  nss_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(spi_en && spi_4wire) |=> hit[7] == '0);

  // R2
  unique_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dup == '0);

  // R8
  exhaust_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|unrouted) |-> pin_claimed[16]);

  for (genvar p = 0; p < 16; p++) begin : g_skip
    localparam int B = p % 8;
    localparam bit P1 = p >= 8;
    logic owned;
    assign owned = (p == 4 || p == 5) ? uart_en :
                   (p == 12) ? cp0a_en : (p == 13) ? cp0_en : 1'b0;
    // R6
    skip_honoured_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((P1 ? p1_skip[B] : p0_skip[B]) && !owned) |=> !pin_claimed[p]);
  end
endmodule

bind pin_route_xbar pin_route_xbar_chk #(.NPINS(NPINS), .NSIG(NSIG), .IW(IW)) u_chk (.*);

// File: tb/tb_pin_route_xbar.sv
`timescale 1ns/1ps
module tb_pin_route_xbar;
  localparam int NP = 17, NS = 17, IW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic uart_en, cp0a_en, cp0_en, spi_en, spi_4wire, smb_en, sysclk_en;
  logic [1:0] pca_chans;
  logic eci_en, t0_en, t1_en;
  logic [7:0] p0_skip, p1_skip;
  logic [NP*IW-1:0] pin_sel;
  logic [NP-1:0] pin_claimed;
  logic [NS-1:0] unrouted;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic [NP*IW-1:0] sel;
    logic [NP-1:0]    clm;
    logic [NS-1:0]    miss;
    string            tag;
  } exp_t;
  exp_t q[$];
  exp_t last;

  always #2.5 clk = ~clk;

  pin_route_xbar dut (.*);

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input string tag);
    exp_t e;
    bit blocked [NP];
    int order [$];
    int p;
    e.sel = '1; e.clm = '0; e.miss = '0; e.tag = tag;
    for (int i = 0; i < NP; i++) blocked[i] = (i < 8) ? p0_skip[i] : (i < 16) ? p1_skip[i-8] : 1'b0;
    if (uart_en) begin
      e.sel[20 +: 5] = 5'd0; e.sel[25 +: 5] = 5'd1; e.clm[4] = 1; e.clm[5] = 1;
      blocked[4] = 1; blocked[5] = 1;
    end
    if (cp0a_en) begin e.sel[60 +: 5] = 5'd2; e.clm[12] = 1; blocked[12] = 1; end
    if (cp0_en)  begin e.sel[65 +: 5] = 5'd3; e.clm[13] = 1; blocked[13] = 1; end
    if (spi_en) begin order.push_back(4); order.push_back(5); order.push_back(6); end
    if (spi_en && spi_4wire) order.push_back(7);
    if (smb_en) begin order.push_back(8); order.push_back(9); end
    if (sysclk_en) order.push_back(10);
    for (int c = 0; c < 3; c++) if (c < pca_chans) order.push_back(11 + c);
    if (eci_en) order.push_back(14);
    if (t0_en) order.push_back(15);
    if (t1_en) order.push_back(16);
    p = 0;
    foreach (order[k]) begin
      while (p < NP && blocked[p]) p++;
      if (p == NP) e.miss[order[k]] = 1'b1;
      else begin
        e.sel[p*5 +: 5] = order[k][4:0]; e.clm[p] = 1'b1; p++;
      end
    end
    return e;
  endfunction

  task automatic set_cfg(input bit u, ca, c, sp, s4, sm, sc, input logic [1:0] pc,
                         input bit ec, a0, a1, input logic [7:0] s0, s1);
    uart_en = u; cp0a_en = ca; cp0_en = c; spi_en = sp; spi_4wire = s4; smb_en = sm;
    sysclk_en = sc; pca_chans = pc; eci_en = ec; t0_en = a0; t1_en = a1;
    p0_skip = s0; p1_skip = s1;
  endtask

  task automatic drive(input bit u, ca, c, sp, s4, sm, sc, input logic [1:0] pc,
                       input bit ec, a0, a1, input logic [7:0] s0, s1, input string tag);
    @(negedge clk);
    set_cfg(u, ca, c, sp, s4, sm, sc, pc, ec, a0, a1, s0, s1);
    q.push_back(model(tag));
  endtask

  task automatic drive_rand();
    logic [31:0] r0;
    logic [31:0] r1;
    r0 = $urandom; r1 = $urandom;
    drive(r0[0], r0[1], r0[2], r0[3], r0[4], r0[5], r0[6], r0[8:7], r0[9], r0[10], r0[11],
          r1[7:0] & r1[15:8], r1[23:16] & r1[31:24], "R2 R3 R6 R8 R11 random");
  endtask

  always begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(pin_sel == e.sel, {e.tag, " pin_sel"}, 128'(pin_sel), 128'(e.sel));
      check(pin_claimed == e.clm, {e.tag, " R10 pin_claimed"}, 128'(pin_claimed), 128'(e.clm));
      check(unrouted == e.miss, {e.tag, " R8 unrouted"}, 128'(unrouted), 128'(e.miss));
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    set_cfg(1, 1, 1, 1, 1, 1, 1, 2'd3, 1, 1, 1, 8'h00, 8'h00);
    repeat (3) @(posedge clk);
    #1;
    // r1_ reset state
    check(pin_sel == '1, "R1 reset pin_sel", 128'(pin_sel), 128'(85'h1FFFFFFFFFFFFFFFFFFFFF));
    check(pin_claimed == '0 && unrouted == '0, "R1 reset flags", 128'({pin_claimed, unrouted}), 128'(0));
    @(negedge clk);
    rst_n = 1'b1;
    set_cfg(0, 0, 0, 0, 0, 0, 0, 2'd0, 0, 0, 0, 8'h00, 8'h00);

    drive(0, 0, 0, 0, 0, 0, 0, 2'd0, 0, 0, 0, 8'h00, 8'h00, "R10 all off");
    drive(1, 0, 0, 0, 0, 0, 0, 2'd0, 0, 0, 0, 8'h00, 8'h00, "R4 uart only");
    drive(1, 0, 0, 0, 0, 0, 0, 2'd0, 0, 0, 0, 8'h30, 8'h00, "R4 uart over skipped pins");
    drive(0, 0, 0, 1, 0, 0, 0, 2'd0, 0, 0, 0, 8'h00, 8'h00, "R7 spi 3-wire");
    drive(1, 0, 0, 1, 1, 0, 0, 2'd0, 0, 0, 0, 8'h00, 8'h00, "R3 R7 spi 4-wire");
    drive(1, 0, 0, 1, 1, 0, 0, 2'd0, 0, 0, 0, 8'h0C, 8'h00, "R6 skip 0x0C");
    drive(0, 1, 1, 0, 0, 0, 0, 2'd0, 0, 0, 0, 8'h00, 8'h30, "R5 comparator fixed");
    drive(1, 1, 1, 1, 1, 1, 1, 2'd3, 1, 1, 1, 8'h00, 8'h00, "R3 R11 exact fill");
    drive(1, 1, 1, 1, 1, 1, 1, 2'd3, 1, 1, 1, 8'h01, 8'h00, "R8 one short");
    drive(0, 0, 0, 1, 1, 0, 0, 2'd0, 0, 0, 0, 8'hFF, 8'hFF, "R8 R6 all skipped");
    drive(0, 0, 0, 0, 0, 1, 0, 2'd2, 0, 1, 0, 8'h00, 8'h00, "R11 pca two");

    @(negedge clk);
    set_cfg(0, 0, 0, 0, 0, 0, 0, 2'd0, 0, 0, 0, 8'h00, 8'h00);
    q.push_back(model("R9 settle"));
    @(posedge clk); #1;
    while (q.size() > 0) @(negedge clk);
    last = model("R9");
    @(negedge clk);
    set_cfg(1, 1, 1, 1, 1, 1, 1, 2'd3, 1, 1, 1, 8'h00, 8'h00);
    #1;
    // R9 no change before the edge
    check(pin_sel == last.sel && pin_claimed == last.clm, "R9 hold between edges",
          128'(pin_sel), 128'(last.sel));
    q.push_back(model("R9 after edge"));

    for (int i = 0; i < 400; i++) drive_rand();

    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule